// File: doc/BRIEF.md
# Receive Defect Change-of-State Interrupt Controller

This block collects eight receive-side alarm and error indications from a DS3 framer and turns them into one active-low interrupt request. Four of them are level defects (loss of signal, alarm indication signal, idle, out of frame). Each of these raises an interrupt on every change of state, both when the defect appears and when it goes away. The other four (C-bit parity error, P-bit parity error, far-end receive failure, application identification channel) arrive as one-cycle event pulses.

Software works the block over a simple 8-bit bus with read and write strobes. It reads a live-state/configuration register, a read/write mask register and a latched cause register. Reading the cause register clears it. While loss of signal is present, the block also requests on its own that the transmitter send a far-end receive failure indication.

Top module: `rx_defect_irq`

## Requirements
- R1: After reset the mask register (0x12), the cause register (0x13) and the configuration bits all read 0x00, `irq_n` is 1 and `ferf_req` is 0.
- R2: The mask register at address 0x12 is read/write. A write stores all eight bits and a later read returns them.
- R3: A source whose mask bit is 0 leaves its cause bit at 0 and does not pull `irq_n` low.
- R4: A rising or falling edge of a level defect sets its cause bit one clock after the edge. The bit positions are LOS=6, AIS=5, idle=4 and OOF=1.
- R5: A one-cycle pulse on an event input sets its cause bit. The bit positions are C-bit error=7, FERF=3, AIC=2 and P-bit error=0.
- R6: A read of address 0x13 returns the cause bits and clears them, so the next read returns 0x00 if nothing new occurred.
- R7: A source that sets its cause bit in the same cycle as a read of 0x13 survives the clear. The read returns the old value and the following read shows the new bit.
- R8: `irq_n` is 0 exactly while some cause bit and its mask bit are both 1. It returns to 1 when a read clears the cause bits or a write clears the mask bits.
- R9: Address 0x10 reads live AIS at bit 7, LOS at bit 6, idle at bit 5 and OOF at bit 4, with bit 3 as 0. Bits 2..0 are read/write configuration (framing-on-parity, F-sync algorithm, M-sync algorithm), and writes to bits 7..3 are ignored.
- R10: `ferf_req` is 1 from one clock after `live_los` goes high until one clock after it goes low, with no software action.
- R11: A read of any address other than 0x10, 0x12 or 0x13 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; read data valid in that cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| live_los | input | 1 | Loss of signal defect level |
| live_ais | input | 1 | AIS defect level |
| live_idle | input | 1 | Idle signal defect level |
| live_oof | input | 1 | Out-of-frame defect level |
| evt_cpbit | input | 1 | C-bit parity error pulse |
| evt_pbit | input | 1 | P-bit parity error pulse |
| evt_ferf | input | 1 | Received far-end failure pulse |
| evt_aic | input | 1 | AIC change pulse |
| cfg_mode | output | 3 | Configuration bits 2..0 of address 0x10 |
| irq_n | output | 1 | Active-low interrupt request |
| ferf_req | output | 1 | Request to transmit FERF |

## Verification
The bench drives the falling edge of each level defect as well as the rising edge. A design that fires only on declaration would leave the cause register at zero after a defect clears. It fires a source in the exact cycle that the cause register is read, which catches a design whose clear wipes out a new event. It clears the mask while a cause bit is still set, so a design that gates `irq_n` by the cause bits alone would keep the request low. It also writes all ones to the live-state register, which would expose a design that lets writes reach the read-only bits.

// File: rtl/rx_defect_irq.sv
module rx_defect_irq #(
  parameter logic [7:0] ADDR_CFG  = 8'h10,
  parameter logic [7:0] ADDR_MASK = 8'h12,
  parameter logic [7:0] ADDR_CAUS = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       live_los,
  input  logic       live_ais,
  input  logic       live_idle,
  input  logic       live_oof,
  input  logic       evt_cpbit,
  input  logic       evt_pbit,
  input  logic       evt_ferf,
  input  logic       evt_aic,
  output logic [2:0] cfg_mode,
  output logic       irq_n,
  output logic       ferf_req
);

  logic [3:0] lvl_q;
  logic [7:0] mask_q, cause_q, hit;
  logic [2:0] cfg_q;
  logic       rd_cause;

  wire [3:0] lvl_now = {live_los, live_ais, live_idle, live_oof};
  wire [3:0] lvl_chg = lvl_now ^ lvl_q;

  assign hit = {evt_cpbit, lvl_chg[3], lvl_chg[2], lvl_chg[1],
                evt_ferf, evt_aic, lvl_chg[0], evt_pbit} & mask_q;
  assign rd_cause = bus_rd && (bus_addr == ADDR_CAUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      mask_q  <= '0;
      cause_q <= '0;
      cfg_q   <= '0;
    end else begin
      lvl_q   <= lvl_now;
      cause_q <= (rd_cause ? 8'h00 : cause_q) | hit;
      if (bus_wr && bus_addr == ADDR_MASK) mask_q <= bus_wdata;
      if (bus_wr && bus_addr == ADDR_CFG)  cfg_q  <= bus_wdata[2:0];
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_CFG:  bus_rdata = {live_ais, live_los, live_idle, live_oof, 1'b0, cfg_q};
        ADDR_MASK: bus_rdata = mask_q;
        ADDR_CAUS: bus_rdata = cause_q;
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  assign irq_n    = ~|(cause_q & mask_q);
  assign ferf_req = lvl_q[3];
  assign cfg_mode = cfg_q;

  a_r3_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(mask_q)) == 8'h00));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cause |=> ((cause_q & ~$past(hit)) == 8'h00));

  a_r7_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && |hit) |=> ((cause_q & $past(hit)) == $past(hit)));

  a_r8_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (cause_q != 8'h00));

  a_r10_ferf_follows_los: assert property (@(posedge clk) disable iff (!rst_n)
    live_los |=> ferf_req);

endmodule

// File: tb/tb_rx_defect_irq.sv
`timescale 1ns/1ps
module tb_rx_defect_irq;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_rdata;
  logic live_los = 0, live_ais = 0, live_idle = 0, live_oof = 0;
  logic evt_cpbit = 0, evt_pbit = 0, evt_ferf = 0, evt_aic = 0;
  logic [2:0] cfg_mode;
  logic irq_n, ferf_req;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rx_defect_irq dut (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_rd = 1; bus_addr = a; tick(); bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0;
  endtask

  always @(negedge clk) if (bus_rd) begin
    if (exp_q.size() == 0) chk("queue", 8'hEE, 8'h00);
    else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 ferf_req", {7'd0, ferf_req}, 8'h00);
    rd(8'h12, 8'h00, "R1 mask");
    rd(8'h13, 8'h00, "R1 cause");
    rd(8'h10, 8'h00, "R1 cfg");
    wr(8'h12, 8'hA5); rd(8'h12, 8'hA5, "R2 mask rw");
    wr(8'h12, 8'hFF); rd(8'h12, 8'hFF, "R2 mask all");
    wr(8'h10, 8'hFF); rd(8'h10, 8'h07, "R9 ro bits ignored");
    chk("R9 cfg_mode", {5'd0, cfg_mode}, 8'h07);
    live_los = 1; tick();
    chk("R10 ferf on", {7'd0, ferf_req}, 8'h01);
    chk("R8 irq low", {7'd0, irq_n}, 8'h00);
    rd(8'h10, 8'h47, "R9 live los");
    rd(8'h13, 8'h40, "R4 los declare");
    rd(8'h13, 8'h00, "R6 cleared");
    chk("R8 irq released", {7'd0, irq_n}, 8'h01);
    live_los = 0; tick();
    chk("R10 ferf off", {7'd0, ferf_req}, 8'h00);
    rd(8'h13, 8'h40, "R4 los clear");
    live_ais = 1; live_idle = 1; live_oof = 1; tick();
    rd(8'h10, 8'hB7, "R9 live ais idle oof");
    rd(8'h13, 8'h32, "R4 ais idle oof");
    evt_cpbit = 1; evt_pbit = 1; evt_ferf = 1; evt_aic = 1; tick();
    evt_cpbit = 0; evt_pbit = 0; evt_ferf = 0; evt_aic = 0;
    rd(8'h13, 8'h8D, "R5 pulses");
    wr(8'h12, 8'h00);
    evt_cpbit = 1; tick(); evt_cpbit = 0;
    live_ais = 0; live_idle = 0; live_oof = 0; tick();
    chk("R3 irq stays high", {7'd0, irq_n}, 8'h01);
    rd(8'h13, 8'h00, "R3 masked sources");
    wr(8'h12, 8'hFF);
    evt_pbit = 1; tick(); evt_pbit = 0;
    chk("R8 irq on pbit", {7'd0, irq_n}, 8'h00);
    wr(8'h12, 8'h00);
    chk("R8 irq masked off", {7'd0, irq_n}, 8'h01);
    rd(8'h13, 8'h01, "R8 cause kept under mask");
    wr(8'h12, 8'hFF);
    evt_aic = 1; rd(8'h13, 8'h00, "R7 read during event"); evt_aic = 0;
    rd(8'h13, 8'h04, "R7 event survived");
    rd(8'h11, 8'h00, "R11 addr 11");
    rd(8'h55, 8'h00, "R11 addr 55");
    tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule